// File: doc/BRIEF.md
# Multi-Core Detector Job Dispatcher with In-Order Result Release

This block sits in front of a pool of detector cores. Each core takes a variable number of cycles per symbol. Symbol jobs arrive on a valid/ready input at a steady rate and wait in a job queue. Whenever the queue holds a job, a core is idle and a sequence tag is free, the head job is handed to the lowest-numbered idle core. The handoff carries a sequence tag and a node budget, which caps the search effort the core may spend. The budget shrinks as the queue fills, so the cores drain faster and the input never has to drop a job.

Cores report completion with a one-cycle done pulse that returns the result and the tag it was given. Completions may arrive in any order. Each result is parked in a reorder buffer slot indexed by its tag. Results leave on a valid/ready output stream strictly in the order their jobs were accepted, and the output holds under backpressure.

Top module: `detector_dispatch`

## Requirements
- R1: A job is accepted on a cycle where `job_valid` and `job_ready` are both high. `job_ready` is low only while the queue holds `FIFO_DEPTH` jobs. Every accepted job is dispatched exactly once, and its result is released exactly once. An offered job that is not accepted has no effect.
- R2: Jobs are dispatched in acceptance order. A dispatch drives `core_start` high for exactly one core during one cycle, with `core_job` equal to the oldest queued job.
- R3: When more than one core is idle, the dispatch goes to the idle core with the lowest index (bit 0 of `core_start` is core 0).
- R4: The node budget depends on the queue occupancy `n` in the dispatch cycle, counting the job being dispatched. If `2n < FIFO_DEPTH`, the budget is `FULL_BUDGET`. If instead `4n <= 3*FIFO_DEPTH`, it is `FULL_BUDGET/2`. Otherwise it is `MIN_BUDGET`.
- R5: `core_tag` of the k-th dispatch since reset (counting from 0) equals k modulo `ROB_DEPTH`.
- R6: No dispatch occurs while `ROB_DEPTH` dispatched jobs have not yet had their results released on the output, even if cores are idle and jobs are queued.
- R7: `out_valid` is high only when the result for the oldest unreleased job has returned. Results are released in job acceptance order, regardless of completion order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: After reset, `job_ready` is high, `out_valid` is low and `core_start` is all zero.
- R10: A core that has been started receives no further start until it has pulsed `core_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Incoming job present |
| job_ready | output | 1 | Queue can accept a job |
| job_data | input | JOB_W | Job payload (receive vector and channel data reference) |
| core_start | output | NUM_CORES | One-hot start pulse per core |
| core_job | output | JOB_W | Job payload for the started core |
| core_budget | output | BUDGET_W | Maximum node count for the started job |
| core_tag | output | log2(ROB_DEPTH) | Sequence tag for the started job |
| core_done | input | NUM_CORES | Per-core completion pulse |
| core_result | input | NUM_CORES*RES_W | Per-core result, core i at bits i*RES_W |
| core_done_tag | input | NUM_CORES*log2(ROB_DEPTH) | Per-core returned tag |
| out_valid | output | 1 | Next in-order result available |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | RES_W | Released result |

## Verification
The bench gives a long job to core 0 and a short one to core 1, so the short job finishes first. A design that released the short job's result early would raise `out_valid` before the long job completes and would break acceptance order. It freezes the cores and fills the queue, then releases them. This checks that the full queue deasserts `job_ready` and does not swallow a job, and that the budget steps through the minimum, half and full values as occupancy falls. An off-by-one threshold would show up as a wrong budget on a specific job. With the output stalled, it confirms that dispatch stops after exactly `ROB_DEPTH` outstanding jobs. A design without that stall would reuse a live tag and overwrite a parked result.

// File: rtl/detector_dispatch.sv
module detector_dispatch #(
  parameter int NUM_CORES   = 4,
  parameter int JOB_W       = 16,
  parameter int RES_W       = 16,
  parameter int BUDGET_W    = 12,
  parameter int FULL_BUDGET = 1024,
  parameter int MIN_BUDGET  = 64,
  parameter int FIFO_DEPTH  = 8,
  parameter int ROB_DEPTH   = 8,
  localparam int TAG_W  = $clog2(ROB_DEPTH),
  localparam int FPTR_W = $clog2(FIFO_DEPTH),
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       job_valid,
  output logic                       job_ready,
  input  logic [JOB_W-1:0]           job_data,
  output logic [NUM_CORES-1:0]       core_start,
  output logic [JOB_W-1:0]           core_job,
  output logic [BUDGET_W-1:0]        core_budget,
  output logic [TAG_W-1:0]           core_tag,
  input  logic [NUM_CORES-1:0]       core_done,
  input  logic [NUM_CORES*RES_W-1:0] core_result,
  input  logic [NUM_CORES*TAG_W-1:0] core_done_tag,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [RES_W-1:0]           out_data
);

  logic [JOB_W-1:0]     fifo_mem [FIFO_DEPTH];
  logic [FPTR_W-1:0]    wr_ptr, rd_ptr;
  logic [FCNT_W-1:0]    fifo_cnt;
  logic [NUM_CORES-1:0] busy_q, grant;
  logic [TAG_W:0]       alloc_ptr, rel_ptr;
  logic [ROB_DEPTH-1:0] rob_vld;
  logic [RES_W-1:0]     rob_mem [ROB_DEPTH];

  wire push     = job_valid & job_ready;
  wire tag_room = (alloc_ptr - rel_ptr) != (TAG_W+1)'(ROB_DEPTH);
  wire dispatch = (fifo_cnt != '0) & tag_room & (|(~busy_q));
  wire release_ = out_valid & out_ready;

  assign job_ready  = fifo_cnt != FCNT_W'(FIFO_DEPTH);
  assign core_start = dispatch ? grant : '0;
  assign core_job   = fifo_mem[rd_ptr];
  assign core_tag   = alloc_ptr[TAG_W-1:0];
  assign out_valid  = rob_vld[rel_ptr[TAG_W-1:0]];
  assign out_data   = rob_mem[rel_ptr[TAG_W-1:0]];

  always_comb begin
    grant = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--)
      if (!busy_q[i]) grant = NUM_CORES'(1) << i;
  end

  always_comb begin
    if (int'(fifo_cnt) * 2 < FIFO_DEPTH)           core_budget = BUDGET_W'(FULL_BUDGET);
    else if (int'(fifo_cnt) * 4 <= 3 * FIFO_DEPTH) core_budget = BUDGET_W'(FULL_BUDGET / 2);
    else                                           core_budget = BUDGET_W'(MIN_BUDGET);
  end

  always_ff @(posedge clk)
    if (push) fifo_mem[wr_ptr] <= job_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      fifo_cnt  <= '0;
      busy_q    <= '0;
      alloc_ptr <= '0;
      rel_ptr   <= '0;
    end else begin
      if (push)     wr_ptr <= wr_ptr + 1'b1;
      if (dispatch) rd_ptr <= rd_ptr + 1'b1;
      fifo_cnt  <= fifo_cnt + FCNT_W'(push) - FCNT_W'(dispatch);
      busy_q    <= (busy_q | core_start) & ~core_done;
      alloc_ptr <= alloc_ptr + (TAG_W+1)'(dispatch);
      rel_ptr   <= rel_ptr + (TAG_W+1)'(release_);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_vld <= '0;
    end else begin
      if (release_) rob_vld[rel_ptr[TAG_W-1:0]] <= 1'b0;
      for (int i = 0; i < NUM_CORES; i++)
        if (core_done[i]) rob_vld[core_done_tag[i*TAG_W +: TAG_W]] <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < NUM_CORES; i++)
      if (core_done[i]) rob_mem[core_done_tag[i*TAG_W +: TAG_W]] <= core_result[i*RES_W +: RES_W];

endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker #(
  parameter int NUM_CORES   = 4,
  parameter int RES_W       = 16,
  parameter int BUDGET_W    = 12,
  parameter int FULL_BUDGET = 1024,
  parameter int FIFO_DEPTH  = 8,
  parameter int ROB_DEPTH   = 8,
  localparam int TAG_W  = $clog2(ROB_DEPTH),
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_start,
  input logic [NUM_CORES-1:0] core_done,
  input logic [NUM_CORES-1:0] busy_q,
  input logic [BUDGET_W-1:0]  core_budget,
  input logic [FCNT_W-1:0]    fifo_cnt,
  input logic [TAG_W:0]       alloc_ptr,
  input logic [TAG_W:0]       rel_ptr,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [RES_W-1:0]     out_data
);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= FIFO_DEPTH);

  assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_start));

  assert_start_has_job_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_start) |-> (fifo_cnt != '0));

  assert_low_fill_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|core_start) && (int'(fifo_cnt) * 2 < FIFO_DEPTH)) |-> (int'(core_budget) == FULL_BUDGET));

  assert_tag_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(alloc_ptr - rel_ptr) <= ROB_DEPTH);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start & busy_q) == '0);

  assert_done_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done & ~busy_q) == '0);

endmodule

bind detector_dispatch dispatch_checker #(
  .NUM_CORES(NUM_CORES), .RES_W(RES_W), .BUDGET_W(BUDGET_W),
  .FULL_BUDGET(FULL_BUDGET), .FIFO_DEPTH(FIFO_DEPTH), .ROB_DEPTH(ROB_DEPTH)
) chk (
  .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_done(core_done),
  .busy_q(busy_q), .core_budget(core_budget), .fifo_cnt(fifo_cnt),
  .alloc_ptr(alloc_ptr), .rel_ptr(rel_ptr), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/detector_dispatch_test.sv
`timescale 1ns/1ps
module detector_dispatch_test;
  localparam int NC = 4, TW = 3;
  localparam int FULL = 1024, HALF = 512, MINB = 64;

  logic clk = 0, rst_n = 0;
  logic job_valid = 0, out_ready = 1;
  logic [15:0] job_data = '0;
  logic job_ready, out_valid;
  logic [NC-1:0] core_start;
  logic [15:0] core_job, out_data;
  logic [11:0] core_budget;
  logic [TW-1:0] core_tag;
  logic [NC-1:0] done_r = '0;
  logic [NC*16-1:0] res_r = '0;
  logic [NC*TW-1:0] dtag_r = '0;

  always #2.5 clk = ~clk;

  detector_dispatch uut (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_data(job_data), .core_start(core_start), .core_job(core_job),
    .core_budget(core_budget), .core_tag(core_tag), .core_done(done_r),
    .core_result(res_r), .core_done_tag(dtag_r), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  int n_tests = 0, n_fail = 0;
  int n_st = 0, n_out = 0, n_push = 0;
  int st_core [64];
  int st_bud [64];
  int st_tag [64];
  logic [15:0] st_job [64];
  logic [15:0] out_log [64];
  logic [15:0] push_log [64];
  bit hold = 0;
  logic m_busy [NC];
  int m_cnt [NC];
  logic [15:0] m_job [NC];
  logic [TW-1:0] m_tag [NC];

  always @(posedge clk) begin
    for (int i = 0; i < NC; i++) begin
      done_r[i] <= 1'b0;
      if (!rst_n) m_busy[i] <= 1'b0;
      else if (core_start[i]) begin
        m_busy[i] <= 1'b1;
        m_cnt[i]  <= int'(core_job[11:8]) + 1;
        m_job[i]  <= core_job;
        m_tag[i]  <= core_tag;
        st_core[n_st] = i; st_bud[n_st] = int'(core_budget);
        st_tag[n_st] = int'(core_tag); st_job[n_st] = core_job;
        n_st++;
      end else if (m_busy[i] && !hold) begin
        if (m_cnt[i] == 1) begin
          done_r[i] <= 1'b1;
          res_r[i*16 +: 16] <= m_job[i] ^ 16'h5A5A;
          dtag_r[i*TW +: TW] <= m_tag[i];
          m_busy[i] <= 1'b0;
        end else m_cnt[i] <= m_cnt[i] - 1;
      end
    end
    if (rst_n && out_valid && out_ready) begin
      out_log[n_out] = out_data;
      n_out++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] d);
    bit rdy;
    job_data = d; job_valid = 1;
    forever begin
      rdy = job_ready;
      @(negedge clk);
      if (rdy) break;
    end
    job_valid = 0;
    push_log[n_push] = d; n_push++;
  endtask

  task automatic drain();
    for (int k = 0; k < 600 && n_out != n_push; k++) @(negedge clk);
    chk(n_out == n_push, "R1 results released", n_out, n_push);
  endtask

  task automatic check_order(input int from);
    int bad = -1;
    for (int k = from; k < n_out; k++)
      if (bad < 0 && out_log[k] != (push_log[k] ^ 16'h5A5A)) bad = k;
    chk(bad < 0, "R7 arrival order", bad < 0 ? 0 : int'(out_log[bad]),
        bad < 0 ? 0 : int'(push_log[bad] ^ 16'h5A5A));
  endtask

  task automatic t_reset();
    chk(job_ready == 1'b1, "R9 job_ready", job_ready, 1);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(core_start == '0, "R9 core_start", core_start, 0);
  endtask

  task automatic t_lowest_idle_ooo();
    int s0 = n_st, o0 = n_out;
    hold = 0; out_ready = 1;
    push(16'h0F01);
    push(16'h0002);
    repeat (5) @(negedge clk);
    chk(st_core[s0] == 0, "R3 first job core", st_core[s0], 0);
    chk(st_core[s0+1] == 1, "R3 second job core", st_core[s0+1], 1);
    chk(out_valid == 1'b0 && n_out == o0, "R7 early finisher held", out_valid, 0);
    push(16'h0003);
    repeat (2) @(negedge clk);
    chk(st_core[s0+2] == 1, "R10 busy core0 skipped", st_core[s0+2], 1);
    drain();
    check_order(o0);
  endtask

  task automatic t_budget_full();
    int s0 = n_st, o0 = n_out;
    int exp_b [8] = '{MINB, MINB, HALF, HALF, HALF, FULL, FULL, FULL};
    int bad = -1;
    hold = 1;
    for (int k = 0; k < 4; k++) push(16'h0010 + 16'(k));
    for (int k = 0; k < 8; k++) push(16'h0020 + 16'(k));
    repeat (2) @(negedge clk);
    chk(job_ready == 1'b0, "R1 full queue not ready", job_ready, 0);
    chk(n_st - s0 == 4, "R10 only idle cores started", n_st - s0, 4);
    job_data = 16'hBEEF; job_valid = 1;
    repeat (3) @(negedge clk);
    job_valid = 0;
    hold = 0;
    drain();
    for (int k = 0; k < 4; k++)
      chk(st_bud[s0+k] == FULL, "R4 low occupancy budget", st_bud[s0+k], FULL);
    for (int k = 0; k < 8; k++)
      if (bad < 0 && st_bud[s0+4+k] != exp_b[k]) bad = k;
    chk(bad < 0, "R4 budget steps", bad < 0 ? 0 : st_bud[s0+4+bad], bad < 0 ? 0 : exp_b[bad]);
    check_order(o0);
  endtask

  task automatic t_tag_stall();
    int s0 = n_st, o0 = n_out, p0 = n_push;
    logic [15:0] d0;
    int bad = -1;
    out_ready = 0;
    for (int k = 0; k < 10; k++) push(16'h0130 + 16'(k));
    repeat (30) @(negedge clk);
    chk(n_st - s0 == 8, "R6 dispatch stall", n_st - s0, 8);
    chk(out_valid == 1'b1 && out_data == (push_log[p0] ^ 16'h5A5A), "R7 head result",
        out_data, push_log[p0] ^ 16'h5A5A);
    d0 = out_data;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == d0, "R8 held under backpressure", out_data, d0);
    out_ready = 1;
    drain();
    check_order(o0);
    for (int k = 0; k < n_st; k++) if (bad < 0 && st_tag[k] != k % 8) bad = k;
    chk(bad < 0, "R5 tag sequence", bad < 0 ? 0 : st_tag[bad], bad < 0 ? 0 : bad % 8);
    bad = -1;
    for (int k = 0; k < n_st; k++) if (bad < 0 && st_job[k] != push_log[k]) bad = k;
    chk(bad < 0 && n_st == n_push, "R2 dispatch order", bad < 0 ? n_st : int'(st_job[bad]),
        bad < 0 ? n_push : int'(push_log[bad]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lowest_idle_ooo();
    t_budget_full();
    t_tag_stall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule